// File: doc/BRIEF.md
# Motion-Adaptive Temporal Noise Filter

This block reduces temporal noise in a stream of 8-bit luminance and chrominance samples. Each live sample is blended with the co-sited sample stored one field or one frame earlier. Both delayed samples come back from an external memory on their own return inputs, and a mode input selects which one is used. The uncorrelated part of the signal, which is mostly noise, is attenuated. A per-pixel movement detector compares the live sample with the delayed one. Where the two differ strongly, the recursion is weakened or turned off, so that moving objects do not smear.

The strength of the recursion comes from a parameter set. A noise-class input selects the set, and the set holds the two motion thresholds and the largest coefficient that class allows. Luma and chroma each have their own user strength code, which picks a coefficient between bypass and 7/8. A 7/8 coefficient gives roughly 12 dB of noise reduction. For demonstrations, a split-screen control turns filtering off on the left half of each active line, so filtered and unfiltered video can be seen side by side. The result is registered once and carries a valid flag.

Top module: `mnr_filter`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock. `out_y` and `out_c` change only on a clock edge where `in_valid` was high, and otherwise hold their value.
- R2: With `frame_sel` = 0 the delayed operand is `fld_y`/`fld_c`. With `frame_sel` = 1 it is `frm_y`/`frm_c`.
- R3: The output is `cur + floor((k8*(dly - cur) + 4) / 8)`, saturated to 0..255, where k8 is the coefficient in eighths. The result always lies between `cur` and `dly`.
- R4: The strength codes `str_y` and `str_c` map to k8 as follows: 0 gives 0 (bypass), 1 gives 4, 2 gives 6 and 3 gives 7. A code above the class maximum is reduced to that maximum.
- R5: `noise_cls` selects the parameter set. Class 0 has maximum code 1, low threshold 4 and high threshold 8. Class 1 has maximum code 2, low threshold 8 and high threshold 16. Classes 2 and 3 have maximum code 3, low threshold 12 and high threshold 24.
- R6: When |cur - dly| exceeds the high threshold, k8 is 0 and the output equals `cur`.
- R7: When |cur - dly| is above the low threshold and at most the high threshold, k8 is halved with the remainder dropped (7→3, 6→3, 4→2). At or below the low threshold, the full k8 is used.
- R8: Luma and chroma each take their own difference, motion decision and strength code, independently of each other.
- R9: A valid pixel that arrives with `sol` high is position 0, and each further valid pixel adds one to the position. When `split_en` is high, positions below LINE_PX/2 leave the block unfiltered (output equals `cur`), and positions from LINE_PX/2 upward are filtered normally.
- R10: While `rst_n` is low, `out_valid`, `out_y` and `out_c` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Live and delayed samples are valid this cycle |
| sol | input | 1 | First valid pixel of an active line |
| frame_sel | input | 1 | 0: field-delayed return, 1: frame-delayed return |
| split_en | input | 1 | Bypass the left half of each line |
| noise_cls | input | 2 | Noise class that selects the parameter set |
| str_y | input | 2 | Luma strength code |
| str_c | input | 2 | Chroma strength code |
| cur_y | input | 8 | Live luma sample |
| cur_c | input | 8 | Live chroma sample |
| fld_y | input | 8 | Luma sample one field earlier |
| fld_c | input | 8 | Chroma sample one field earlier |
| frm_y | input | 8 | Luma sample one frame earlier |
| frm_c | input | 8 | Chroma sample one frame earlier |
| out_valid | output | 1 | Output samples are valid |
| out_y | output | 8 | Filtered luma |
| out_c | output | 8 | Filtered chroma |

## Verification
The hardest condition to reach from the ports is a difference that sits exactly on a class threshold. At that point the motion decision changes between full, halved and zero recursion by a single code step. The stimulus table places pairs of samples at exactly the low and high thresholds and one step above each, under several classes, with luma and chroma on opposite sides of a threshold in the same pixel. The split-screen check uses a shortened line length so that the bench can walk a whole line. It starts the line with `sol` after other pixels have already moved the position counter, which confirms that the counter restarts at the line start.

// File: rtl/nr_pkg.sv
package nr_pkg;
  localparam int PIX_W = 8;
  localparam int K_W   = 3;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [K_W-1:0]   k8_t;

  typedef struct packed {
    pix_t       lo;
    pix_t       hi;
    logic [1:0] max_code;
  } nr_set_t;

  // Parameter set per noise class: cleaner input gets tighter thresholds.
  function automatic nr_set_t class_set(input logic [1:0] cls);
    nr_set_t s;
    case (cls)
      2'd0:    begin s.lo = 8'd4;  s.hi = 8'd8;  s.max_code = 2'd1; end
      2'd1:    begin s.lo = 8'd8;  s.hi = 8'd16; s.max_code = 2'd2; end
      default: begin s.lo = 8'd12; s.hi = 8'd24; s.max_code = 2'd3; end
    endcase
    return s;
  endfunction

  // Strength code to coefficient in eighths.
  function automatic k8_t code_to_k8(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd0;
      2'd1:    return 3'd4;
      2'd2:    return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic pix_t abs_diff(input pix_t a, input pix_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // cur + round(k8/8 * (dly - cur)), rounding half up, saturated.
  function automatic pix_t blend(input pix_t cur, input pix_t dly, input k8_t k8);
    logic signed [13:0] d;
    logic signed [13:0] p;
    logic signed [13:0] s;
    d = $signed({6'b0, dly}) - $signed({6'b0, cur});
    p = d * $signed({11'b0, k8});
    p = (p + 14'sd4) >>> 3;
    s = $signed({6'b0, cur}) + p;
    if (s < 14'sd0)        return 8'd0;
    else if (s > 14'sd255) return 8'd255;
    else                   return s[7:0];
  endfunction
endpackage

// File: rtl/nr_line_pos.sv
module nr_line_pos #(
  parameter int LINE_PX = 720
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic sol,
  output logic left_half
);
  localparam int CW   = $clog2(LINE_PX + 1);
  localparam int HALF = LINE_PX / 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pos;

  always_comb begin
    pos       = sol ? '0 : cnt_q;
    left_half = (pos < CW'(HALF));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (in_valid && (pos != CW'(LINE_PX)))
      cnt_q <= pos + 1'b1;
    else if (in_valid)
      cnt_q <= pos;
  end
endmodule

// File: rtl/nr_coef_sel.sv
module nr_coef_sel
  import nr_pkg::*;
(
  input  pix_t       cur,
  input  pix_t       dly,
  input  logic [1:0] cls,
  input  logic [1:0] strength,
  input  logic       force_bypass,
  output k8_t        k8,
  output logic       motion_hi,
  output logic       motion_mid
);
  nr_set_t    set;
  logic [1:0] code;
  k8_t        base;
  pix_t       diff;

  always_comb begin
    set        = class_set(cls);
    code       = (strength > set.max_code) ? set.max_code : strength;
    base       = code_to_k8(code);
    diff       = abs_diff(cur, dly);
    motion_hi  = diff > set.hi;
    motion_mid = !motion_hi && (diff > set.lo);
    if (force_bypass || motion_hi) k8 = '0;
    else if (motion_mid)           k8 = base >> 1;
    else                           k8 = base;
  end
endmodule

// File: rtl/nr_blend_reg.sv
module nr_blend_reg
  import nr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  pix_t cur,
  input  pix_t dly,
  input  k8_t  k8,
  output pix_t out
);
  always_ff @(posedge clk) begin
    if (!rst_n)  out <= '0;
    else if (en) out <= blend(cur, dly, k8);
  end
endmodule

// File: rtl/mnr_filter.sv
module mnr_filter
  import nr_pkg::*;
#(
  parameter int LINE_PX = 720
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       sol,
  input  logic       frame_sel,
  input  logic       split_en,
  input  logic [1:0] noise_cls,
  input  logic [1:0] str_y,
  input  logic [1:0] str_c,
  input  logic [7:0] cur_y,
  input  logic [7:0] cur_c,
  input  logic [7:0] fld_y,
  input  logic [7:0] fld_c,
  input  logic [7:0] frm_y,
  input  logic [7:0] frm_c,
  output logic       out_valid,
  output logic [7:0] out_y,
  output logic [7:0] out_c
);
  localparam int NCOMP = 2;

  // Named internal events, also used by the checker.
  logic left_half;
  logic split_bypass;
  pix_t dly_y_sel, dly_c_sel;
  k8_t  k8_y, k8_c;
  logic mot_hi_y, mot_hi_c;

  pix_t       cur_a  [NCOMP];
  pix_t       dly_a  [NCOMP];
  logic [1:0] str_a  [NCOMP];
  k8_t        k8_a   [NCOMP];
  logic       hi_a   [NCOMP];
  logic       mid_a  [NCOMP];
  pix_t       out_a  [NCOMP];

  nr_line_pos #(.LINE_PX(LINE_PX)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sol       (sol),
    .left_half (left_half)
  );

  always_comb begin
    dly_y_sel    = frame_sel ? frm_y : fld_y;
    dly_c_sel    = frame_sel ? frm_c : fld_c;
    split_bypass = split_en && left_half;
    cur_a[0] = cur_y;     cur_a[1] = cur_c;
    dly_a[0] = dly_y_sel; dly_a[1] = dly_c_sel;
    str_a[0] = str_y;     str_a[1] = str_c;
  end

  for (genvar i = 0; i < NCOMP; i++) begin : g_comp
    nr_coef_sel u_sel (
      .cur          (cur_a[i]),
      .dly          (dly_a[i]),
      .cls          (noise_cls),
      .strength     (str_a[i]),
      .force_bypass (split_bypass),
      .k8           (k8_a[i]),
      .motion_hi    (hi_a[i]),
      .motion_mid   (mid_a[i])
    );
    nr_blend_reg u_blend (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .cur   (cur_a[i]),
      .dly   (dly_a[i]),
      .k8    (k8_a[i]),
      .out   (out_a[i])
    );
  end

  always_comb begin
    k8_y     = k8_a[0];
    k8_c     = k8_a[1];
    mot_hi_y = hi_a[0];
    mot_hi_c = hi_a[1];
    out_y    = out_a[0];
    out_c    = out_a[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end
endmodule

// File: rtl/nr_checker.sv
module nr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       split_bypass,
  input logic [7:0] cur_y,
  input logic [7:0] cur_c,
  input logic [7:0] dly_y,
  input logic [7:0] dly_c,
  input logic       mot_hi_y,
  input logic       mot_hi_c,
  input logic [2:0] k8_y,
  input logic [2:0] k8_c,
  input logic [1:0] str_y,
  input logic       out_valid,
  input logic [7:0] out_y,
  input logic [7:0] out_c
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_NOVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_y) && $stable(out_c))); // R1
  AST_Y_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_y >= $past(cur_y) && out_y <= $past(dly_y)) ||
                  (out_y <= $past(cur_y) && out_y >= $past(dly_y)))); // R3
  AST_C_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_c >= $past(cur_c) && out_c <= $past(dly_c)) ||
                  (out_c <= $past(cur_c) && out_c >= $past(dly_c)))); // R3
  AST_STR0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && str_y == 2'd0) |=> (out_y == $past(cur_y))); // R4
  AST_MOTION_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mot_hi_y) |=> (out_y == $past(cur_y))); // R6
  AST_MOTION_C: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mot_hi_c) |=> (out_c == $past(cur_c))); // R6
  AST_SPLIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && split_bypass) |=> (out_y == $past(cur_y) && out_c == $past(cur_c))); // R9

  always_comb begin
    if (rst_n) begin
      AST_K_LEGAL: assert (k8_y != 3'd1 && k8_y != 3'd5 && k8_c != 3'd1 && k8_c != 3'd5); // R7
    end
  end
endmodule

bind mnr_filter nr_checker u_nr_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .split_bypass (split_bypass),
  .cur_y        (cur_y),
  .cur_c        (cur_c),
  .dly_y        (dly_y_sel),
  .dly_c        (dly_c_sel),
  .mot_hi_y     (mot_hi_y),
  .mot_hi_c     (mot_hi_c),
  .k8_y         (k8_y),
  .k8_c         (k8_c),
  .str_y        (str_y),
  .out_valid    (out_valid),
  .out_y        (out_y),
  .out_c        (out_c)
);

// File: tb/mnr_filter_bench.sv
module mnr_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_PX    = 16;
  localparam int NVEC       = 12;

  // {cls, str_y, str_c, cur_y, dly_y, cur_c, dly_c}
  localparam logic [37:0] VEC [NVEC] = '{
    {2'd2, 2'd3, 2'd3, 8'd100, 8'd104, 8'd128, 8'd124},
    {2'd2, 2'd3, 2'd3, 8'd50,  8'd70,  8'd200, 8'd190},
    {2'd2, 2'd3, 2'd3, 8'd10,  8'd40,  8'd0,   8'd30 },
    {2'd0, 2'd3, 2'd2, 8'd80,  8'd84,  8'd90,  8'd86 },
    {2'd1, 2'd2, 2'd1, 8'd60,  8'd68,  8'd60,  8'd52 },
    {2'd1, 2'd0, 2'd3, 8'd33,  8'd35,  8'd33,  8'd35 },
    {2'd2, 2'd3, 2'd3, 8'd255, 8'd250, 8'd0,   8'd5  },
    {2'd3, 2'd3, 2'd1, 8'd7,   8'd19,  8'd19,  8'd7  },
    {2'd1, 2'd3, 2'd3, 8'd120, 8'd136, 8'd120, 8'd137},
    {2'd0, 2'd1, 2'd1, 8'd200, 8'd204, 8'd200, 8'd205},
    {2'd2, 2'd2, 2'd3, 8'd1,   8'd2,   8'd254, 8'd253},
    {2'd1, 2'd3, 2'd3, 8'd128, 8'd128, 8'd77,  8'd85 }
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, sol, frame_sel, split_en;
  logic [1:0] noise_cls, str_y, str_c;
  logic [7:0] cur_y, cur_c, fld_y, fld_c, frm_y, frm_c;
  logic       out_valid;
  logic [7:0] out_y, out_c;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mnr_filter #(.LINE_PX(LINE_PX)) u_mnr_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sol(sol),
    .frame_sel(frame_sel), .split_en(split_en), .noise_cls(noise_cls),
    .str_y(str_y), .str_c(str_c), .cur_y(cur_y), .cur_c(cur_c),
    .fld_y(fld_y), .fld_c(fld_c), .frm_y(frm_y), .frm_c(frm_c),
    .out_valid(out_valid), .out_y(out_y), .out_c(out_c)
  );

  // Reference: restates the requirements with plain integers.
  function automatic int ref_pix(int cur, int dly, int cls, int str, bit bypass);
    int lo, hi, mx, code, k, diff, t, q, r;
    if (cls == 0)      begin lo = 4;  hi = 8;  mx = 1; end
    else if (cls == 1) begin lo = 8;  hi = 16; mx = 2; end
    else               begin lo = 12; hi = 24; mx = 3; end
    code = (str > mx) ? mx : str;
    k = (code == 0) ? 0 : (code == 1) ? 4 : (code == 2) ? 6 : 7;
    diff = (cur > dly) ? cur - dly : dly - cur;
    if (bypass || diff > hi) k = 0;
    else if (diff > lo)      k = k / 2;
    t = k * (dly - cur) + 4;
    q = (t >= 0) ? t / 8 : -((-t + 7) / 8);
    r = cur + q;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // Drive one pixel at a negedge, sample at the next negedge.
  task automatic pixel(input int cls, input int sy, input int sc,
                       input int cy, input int dy, input int cc, input int dc,
                       input bit fsel, input bit start);
    noise_cls = 2'(cls); str_y = 2'(sy); str_c = 2'(sc);
    cur_y = 8'(cy); cur_c = 8'(cc);
    frame_sel = fsel; sol = start; in_valid = 1'b1;
    if (fsel) begin frm_y = 8'(dy); frm_c = 8'(dc); fld_y = ~8'(dy); fld_c = ~8'(dc); end
    else      begin fld_y = 8'(dy); fld_c = 8'(dc); frm_y = ~8'(dy); frm_c = ~8'(dc); end
    @(negedge clk);
    sol = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; sol = 1'b0; frame_sel = 1'b0; split_en = 1'b0;
    noise_cls = 2'd2; str_y = 2'd3; str_c = 2'd3;
    cur_y = 8'd90; cur_c = 8'd90; fld_y = 8'd99; fld_c = 8'd99; frm_y = 8'd1; frm_c = 8'd1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 out_valid", int'(out_valid), 0);
    check("R10 out_y", int'(out_y), 0);
    check("R10 out_c", int'(out_c), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // Table: R3 R4 R5 R6 R7 R8 via the reference function, field return
    for (int i = 0; i < NVEC; i++) begin
      int cls, sy, sc, cy, dy, cc, dc;
      cls = int'(VEC[i][37:36]); sy = int'(VEC[i][35:34]); sc = int'(VEC[i][33:32]);
      cy = int'(VEC[i][31:24]); dy = int'(VEC[i][23:16]);
      cc = int'(VEC[i][15:8]);  dc = int'(VEC[i][7:0]);
      pixel(cls, sy, sc, cy, dy, cc, dc, 1'b0, 1'b0);
      check("R3 R5 table luma", int'(out_y), ref_pix(cy, dy, cls, sy, 1'b0));
      check("R4 R7 table chroma", int'(out_c), ref_pix(cc, dc, cls, sc, 1'b0));
      check("R1 valid", int'(out_valid), 1);
    end

    // R6 / R7 boundaries, hand values: class 1, diff 16 -> k 3, diff 17 -> bypass
    pixel(1, 3, 3, 120, 136, 120, 137, 1'b0, 1'b0);
    check("R7 diff at high threshold", int'(out_y), 126);
    check("R6 diff above high threshold", int'(out_c), 120);
    // class 0, diff 4 full k4, diff 5 halved k2
    pixel(0, 1, 1, 200, 204, 200, 205, 1'b0, 1'b0);
    check("R7 diff at low threshold", int'(out_y), 202);
    check("R7 diff above low threshold", int'(out_c), 201);
    // R5 class 0 caps code 3 to 1 (k 4): 80 -> 84 gives 82
    pixel(0, 3, 3, 80, 84, 80, 84, 1'b0, 1'b0);
    check("R5 class cap", int'(out_y), 82);
    // R3 rounding of negative difference: 104 -> 100, k7 gives 101
    pixel(2, 3, 3, 104, 100, 100, 104, 1'b0, 1'b0);
    check("R3 negative rounding", int'(out_y), 101);
    check("R3 positive rounding", int'(out_c), 104);

    // R2: frame return selected, field carries inverted data
    pixel(2, 3, 3, 100, 108, 60, 52, 1'b1, 1'b0);
    check("R2 frame luma", int'(out_y), ref_pix(100, 108, 2, 3, 1'b0));
    check("R2 frame chroma", int'(out_c), ref_pix(60, 52, 2, 3, 1'b0));

    // R8: luma in motion, chroma still; luma strength 0 vs chroma 3
    pixel(2, 3, 3, 0, 200, 100, 102, 1'b0, 1'b0);
    check("R8 luma motion", int'(out_y), 0);
    check("R8 chroma filtered", int'(out_c), 102);
    pixel(2, 0, 3, 40, 44, 40, 44, 1'b0, 1'b0);
    check("R8 luma strength 0", int'(out_y), 40);
    check("R8 chroma strength 3", int'(out_c), 44);

    // R1: idle cycle, outputs hold
    in_valid = 1'b0; cur_y = 8'd9; cur_c = 8'd9; fld_y = 8'd250; fld_c = 8'd250;
    @(negedge clk);
    check("R1 idle valid", int'(out_valid), 0);
    check("R1 idle hold luma", int'(out_y), 40);
    check("R1 idle hold chroma", int'(out_c), 44);

    // R9: split screen over one line starting with sol
    split_en = 1'b1;
    for (int p = 0; p < LINE_PX; p++) begin
      pixel(2, 3, 3, 100, 104, 50, 46, 1'b0, p == 0);
      check("R9 split luma", int'(out_y), (p < LINE_PX/2) ? 100 : 104);
      check("R9 split chroma", int'(out_c), (p < LINE_PX/2) ? 50 : 47);
    end
    split_en = 1'b0;
    pixel(2, 3, 3, 100, 104, 50, 46, 1'b0, 1'b0);
    check("R9 split off", int'(out_y), 104);
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule